// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block is the host-facing half of a dot-matrix character display controller. A host presents one access per cycle on an 8-bit bus, qualified by a strobe and two select lines: one chooses between the instruction path and the data path, and the other chooses between write and read. The block decodes each instruction byte and acts on it. It holds the display RAM (80 bytes) and the character-pattern RAM (64 bytes) behind one shared address counter. It keeps the mode flags that a downstream pixel engine would consume, and it answers status reads with a busy flag and the address counter.

Each accepted access except a status read makes the block busy for a number of clock cycles. The count comes from a clock-rate parameter and depends on the kind of access. While the block is busy, any access other than a status read is dropped and an error pulse is raised. The address counter steps after each data access, in the direction held in the mode flags. In two-line mode it jumps the gap between the two line windows.

Top module: `chardisp_ctrl`

## Requirements
- R1: Each access is one cycle with `acc_valid`=1. {`acc_rs`,`acc_rw`} selects the kind: 00 instruction write, 01 status read, 10 data write, 11 data read. After reset the address counter is 0x00, display RAM is selected, every display RAM byte is 0x20, every pattern RAM byte is 0x00, `acc_rdata`=0x00, `busy`=0, `err_pulse`=0 and `mode_bits`=0x02.
- R2: A status read is accepted even while busy and has no side effect. On the next cycle `acc_rdata` shows the busy flag as it was in the access cycle on bit 7, and the address counter on bits 6..0.
- R3: An accepted data write stores the byte at the address counter in the selected RAM. An accepted data read puts that byte on `acc_rdata` on the next cycle. Both then step the counter: up when the increment flag (`mode_bits`[1]) is 1, down when it is 0.
- R4: An instruction is decoded by its highest set bit. 0x04|I<<1|S stores the increment flag I in `mode_bits`[1] and the shift enable S in [0]. 0x08|D<<2|C<<1|B stores display on (D, [4]), cursor (C, [3]) and blink (B, [2]). 0x20|L<<4|N<<3|F<<2 stores the 8-bit bus flag (L, [7]), two-line mode (N, [6]) and the tall font (F, [5]). An instruction byte of 0x00 changes nothing.
- R5: Clear (0x01) writes 0x20 to every display RAM byte, sets the counter to 0x00, sets the increment flag and selects display RAM.
- R6: Home (0x02 or 0x03) sets the counter to 0x00 and selects display RAM. RAM contents are left unchanged.
- R7: 0x40|A loads the 6-bit address A and selects pattern RAM. 0x80|A loads the 7-bit address A and selects display RAM. While pattern RAM is selected, the counter steps modulo 64.
- R8: In two-line mode the valid display addresses are 0x00–0x27 and 0x40–0x67. Stepping up goes from 0x27 to 0x40 and from 0x67 to 0x00. Stepping down goes from 0x40 to 0x27 and from 0x00 to 0x67.
- R9: In one-line mode the valid display addresses are 0x00–0x4F, and the counter wraps between 0x4F and 0x00 in both directions. The storage is shared between the modes: two-line address 0x40+k is the same byte as one-line address 0x28+k.
- R10: At a display address outside the valid window, a data write changes no RAM and a data read returns 0x00. The counter still steps by plus or minus one, modulo 128.
- R11: 0x10|S<<3|R<<2 with S=0 steps the counter once, up when R=1 and down when R=0, using the wrap rules of the selected RAM and mode. With S=1 the counter does not change.
- R12: After an accepted clear or home, `busy` is high for floor(CLK_KHZ*1530/1000) cycles. After a data write or read it is high for floor(CLK_KHZ*43/1000) cycles. After any other instruction it is high for floor(CLK_KHZ*39/1000) cycles. Every count is at least 1, and `busy` is high starting in the cycle after the access.
- R13: While `busy` is high, any access other than a status read changes no state, and `err_pulse` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_rs | input | 1 | 1 selects the data path, 0 the instruction/status path |
| acc_rw | input | 1 | 1 read, 0 write |
| acc_wdata | input | 8 | Instruction or data byte |
| acc_rdata | output | 8 | Result of the most recent read |
| busy | output | 1 | Internal operation in progress |
| err_pulse | output | 1 | An access was dropped because the block was busy |
| mode_bits | output | 8 | {bus8, two_line, tall_font, display_on, cursor, blink, increment, shift_enable} |

## Verification
The hardest cases to reach are the counter wrap points. Stepping across the 0x27/0x40 gap and around 0x67/0x00 needs two-line mode, a counter placed next to the edge, and each increment direction. The bench gets there by loading the address, choosing the direction, and then making data writes or cursor steps, reading the counter back with status reads after each one. Reaching the shared storage between modes takes one more step: the bench fills all 80 bytes in one-line mode, switches to two-line mode, and reads back through the second-line window. Dropped accesses are made by issuing a write in the cycle right after an accepted one, and status reads show that the counter did not move.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

   localparam int unsigned DATA_W     = 8;
   localparam int unsigned ADDR_W     = 7;
   localparam int unsigned DD_DEPTH   = 80;
   localparam int unsigned CG_DEPTH   = 64;
   localparam int unsigned LINE_LEN   = DD_DEPTH / 2;
   localparam int unsigned LINE2_BASE = 64;
   localparam int unsigned DD_IDX_W   = $clog2(DD_DEPTH);
   localparam int unsigned CG_IDX_W   = $clog2(CG_DEPTH);

   localparam logic [DATA_W-1:0] SPACE_CODE = 8'h20;
   localparam logic [ADDR_W-1:0] L1_LAST    = ADDR_W'(LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] L2_FIRST   = ADDR_W'(LINE2_BASE);
   localparam logic [ADDR_W-1:0] L2_LAST    = ADDR_W'(LINE2_BASE + LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] ONE_LAST   = ADDR_W'(DD_DEPTH - 1);
   localparam logic [ADDR_W-1:0] CG_MASK    = ADDR_W'(CG_DEPTH - 1);

   typedef enum logic [3:0] {
      OP_NONE, OP_STATUS, OP_WRITE, OP_READ, OP_CLEAR, OP_HOME, OP_ENTRY,
      OP_DISPCTL, OP_SHIFT, OP_FUNC, OP_SET_CG, OP_SET_DD, OP_NOP
   } op_e;

   typedef enum logic [1:0] {DLY_NONE, DLY_SHORT, DLY_DATA, DLY_LONG} dly_e;

   typedef struct packed {
      op_e               op;
      dly_e              dly;
      logic [ADDR_W-1:0] arg;
   } cmd_t;

   typedef struct packed {
      logic                hit;
      logic [DD_IDX_W-1:0] idx;
   } dd_loc_t;

   // Display address to physical cell, per line mode
   function automatic dd_loc_t dd_map(input logic [ADDR_W-1:0] a, input logic two_line);
      dd_loc_t r;
      r.hit = 1'b0;
      r.idx = '0;
      if (two_line) begin
         if (a <= L1_LAST) begin
            r.hit = 1'b1;
            r.idx = DD_IDX_W'(a);
         end else if (a >= L2_FIRST && a <= L2_LAST) begin
            r.hit = 1'b1;
            r.idx = DD_IDX_W'(a - L2_FIRST + ADDR_W'(LINE_LEN));
         end
      end else if (a <= ONE_LAST) begin
         r.hit = 1'b1;
         r.idx = DD_IDX_W'(a);
      end
      return r;
   endfunction

   // Next counter value for one step in a given direction
   function automatic logic [ADDR_W-1:0] ac_step(input logic [ADDR_W-1:0] a, input logic up,
                                                 input logic cg, input logic two_line);
      logic [ADDR_W-1:0] n;
      if (cg) begin
         n = up ? (a + 1'b1) & CG_MASK : (a - 1'b1) & CG_MASK;
      end else if (two_line) begin
         if (up)                n = (a == L1_LAST) ? L2_FIRST : (a == L2_LAST) ? '0 : a + 1'b1;
         else                   n = (a == L2_FIRST) ? L1_LAST : (a == '0) ? L2_LAST : a - 1'b1;
      end else begin
         if (up)                n = (a == ONE_LAST) ? '0 : a + 1'b1;
         else                   n = (a == '0) ? ONE_LAST : a - 1'b1;
      end
      return n;
   endfunction

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
   import chardisp_pkg::*;
(
   input  logic              acc_valid,
   input  logic              acc_rs,
   input  logic              acc_rw,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              busy,
   output cmd_t              cmd,
   output logic              reject
);

   always_comb begin
      cmd.op  = OP_NONE;
      cmd.dly = DLY_NONE;
      cmd.arg = acc_wdata[ADDR_W-1:0];
      reject  = 1'b0;
      if (acc_valid) begin
         if (!acc_rs && acc_rw) begin
            cmd.op = OP_STATUS;
         end else if (busy) begin
            reject = 1'b1;
         end else if (acc_rs) begin
            cmd.op  = acc_rw ? OP_READ : OP_WRITE;
            cmd.dly = DLY_DATA;
         end else begin
            cmd.dly = DLY_SHORT;
            casez (acc_wdata)
               8'b1???_????: cmd.op = OP_SET_DD;
               8'b01??_????: cmd.op = OP_SET_CG;
               8'b001?_????: cmd.op = OP_FUNC;
               8'b0001_????: cmd.op = OP_SHIFT;
               8'b0000_1???: cmd.op = OP_DISPCTL;
               8'b0000_01??: cmd.op = OP_ENTRY;
               8'b0000_001?: begin
                  cmd.op  = OP_HOME;
                  cmd.dly = DLY_LONG;
               end
               8'b0000_0001: begin
                  cmd.op  = OP_CLEAR;
                  cmd.dly = DLY_LONG;
               end
               default:      cmd.op = OP_NOP;
            endcase
         end
      end
   end

endmodule

// File: rtl/chardisp_busy_timer.sv
module chardisp_busy_timer
   import chardisp_pkg::*;
#(
   parameter int unsigned CLK_KHZ   = 1000,
   parameter int unsigned LONG_US_X = 1530,
   parameter int unsigned DATA_US   = 43,
   parameter int unsigned SHORT_US  = 39
) (
   input  logic clk,
   input  logic rst_n,
   input  dly_e load,
   output logic busy
);

   localparam int unsigned LONG_RAW  = (CLK_KHZ * LONG_US_X) / 1000;
   localparam int unsigned DATA_RAW  = (CLK_KHZ * DATA_US) / 1000;
   localparam int unsigned SHORT_RAW = (CLK_KHZ * SHORT_US) / 1000;
   localparam int unsigned LONG_CYC  = (LONG_RAW  < 1) ? 1 : LONG_RAW;
   localparam int unsigned DATA_CYC  = (DATA_RAW  < 1) ? 1 : DATA_RAW;
   localparam int unsigned SHORT_CYC = (SHORT_RAW < 1) ? 1 : SHORT_RAW;
   localparam int unsigned CNT_W     = $clog2(LONG_CYC + 1);

   if (CLK_KHZ < 1 || CLK_KHZ > 1000000) begin : g_bad_clk
      $error("chardisp_busy_timer: CLK_KHZ out of range");
   end
   if (LONG_CYC < DATA_CYC || LONG_CYC < SHORT_CYC) begin : g_bad_order
      $error("chardisp_busy_timer: long delay must be the largest");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (load)
            DLY_LONG:  cnt_q <= CNT_W'(LONG_CYC);
            DLY_DATA:  cnt_q <= CNT_W'(DATA_CYC);
            DLY_SHORT: cnt_q <= CNT_W'(SHORT_CYC);
            default:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         endcase
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/chardisp_regfile.sv
module chardisp_regfile #(
   parameter int unsigned DEPTH    = 80,
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] INIT    = '0,
   parameter bit           HAS_FILL = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic                     fill,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [W-1:0]             rdata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("chardisp_regfile: DEPTH must be at least 2");
   end

   logic [W-1:0] mem_q [DEPTH];
   logic         do_fill;

   if (HAS_FILL) begin : g_fill
      assign do_fill = fill;
   end else begin : g_nofill
      assign do_fill = fill & 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= INIT;
      end else if (do_fill) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= INIT;
      end else if (we && (32'(waddr) < DEPTH)) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = (32'(raddr) < DEPTH) ? mem_q[raddr] : '0;

endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
   import chardisp_pkg::*;
#(
   parameter int unsigned CLK_KHZ = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_valid,
   input  logic       acc_rs,
   input  logic       acc_rw,
   input  logic [7:0] acc_wdata,
   output logic [7:0] acc_rdata,
   output logic       busy,
   output logic       err_pulse,
   output logic [7:0] mode_bits
);

   cmd_t              cmd;
   logic              reject;
   logic [ADDR_W-1:0] ac_q;
   logic              cg_sel_q;
   logic              sh_q, inc_q, blink_q, cur_q, disp_q, font_q, two_q, bus8_q;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;
   dd_loc_t           dd_loc;
   logic [DATA_W-1:0] dd_rd, cg_rd, rd_val;
   logic [ADDR_W-1:0] step_data, step_shift;

   chardisp_decode i_decode (
      .acc_valid (acc_valid),
      .acc_rs    (acc_rs),
      .acc_rw    (acc_rw),
      .acc_wdata (acc_wdata),
      .busy      (busy),
      .cmd       (cmd),
      .reject    (reject)
   );

   chardisp_busy_timer #(.CLK_KHZ(CLK_KHZ)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cmd.dly),
      .busy  (busy)
   );

   assign dd_loc = dd_map(ac_q, two_q);

   chardisp_regfile #(
      .DEPTH(DD_DEPTH), .W(DATA_W), .INIT(SPACE_CODE), .HAS_FILL(1'b1)
   ) i_ddram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    ((cmd.op == OP_WRITE) && !cg_sel_q && dd_loc.hit),
      .waddr (dd_loc.idx),
      .wdata (acc_wdata),
      .fill  (cmd.op == OP_CLEAR),
      .raddr (dd_loc.idx),
      .rdata (dd_rd)
   );

   chardisp_regfile #(
      .DEPTH(CG_DEPTH), .W(DATA_W), .INIT('0), .HAS_FILL(1'b0)
   ) i_cgram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    ((cmd.op == OP_WRITE) && cg_sel_q),
      .waddr (ac_q[CG_IDX_W-1:0]),
      .wdata (acc_wdata),
      .fill  (1'b0),
      .raddr (ac_q[CG_IDX_W-1:0]),
      .rdata (cg_rd)
   );

   assign rd_val     = cg_sel_q ? cg_rd : (dd_loc.hit ? dd_rd : '0);
   assign step_data  = ac_step(ac_q, inc_q, cg_sel_q, two_q);
   assign step_shift = ac_step(ac_q, cmd.arg[2], cg_sel_q, two_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q     <= '0;
         cg_sel_q <= 1'b0;
         sh_q     <= 1'b0;
         inc_q    <= 1'b1;
         blink_q  <= 1'b0;
         cur_q    <= 1'b0;
         disp_q   <= 1'b0;
         font_q   <= 1'b0;
         two_q    <= 1'b0;
         bus8_q   <= 1'b0;
         rdata_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= reject;
         unique case (cmd.op)
            OP_STATUS:  rdata_q <= {busy, ac_q};
            OP_WRITE:   ac_q <= step_data;
            OP_READ: begin
               rdata_q <= rd_val;
               ac_q    <= step_data;
            end
            OP_CLEAR: begin
               ac_q     <= '0;
               inc_q    <= 1'b1;
               cg_sel_q <= 1'b0;
            end
            OP_HOME: begin
               ac_q     <= '0;
               cg_sel_q <= 1'b0;
            end
            OP_ENTRY: begin
               inc_q <= cmd.arg[1];
               sh_q  <= cmd.arg[0];
            end
            OP_DISPCTL: begin
               disp_q  <= cmd.arg[2];
               cur_q   <= cmd.arg[1];
               blink_q <= cmd.arg[0];
            end
            OP_SHIFT:   if (!cmd.arg[3]) ac_q <= step_shift;
            OP_FUNC: begin
               bus8_q <= cmd.arg[4];
               two_q  <= cmd.arg[3];
               font_q <= cmd.arg[2];
            end
            OP_SET_CG: begin
               ac_q     <= cmd.arg & CG_MASK;
               cg_sel_q <= 1'b1;
            end
            OP_SET_DD: begin
               ac_q     <= cmd.arg;
               cg_sel_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign acc_rdata = rdata_q;
   assign err_pulse = err_q;
   assign mode_bits = {bus8_q, two_q, font_q, disp_q, cur_q, blink_q, inc_q, sh_q};

endmodule

// File: rtl/chardisp_chk.sv
module chardisp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_valid,
   input logic       acc_rs,
   input logic       acc_rw,
   input logic [7:0] acc_wdata,
   input logic [7:0] acc_rdata,
   input logic       busy,
   input logic       err_pulse,
   input logic [7:0] mode_bits,
   input logic [6:0] ac_q
);

   AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_rs && acc_rw) |=> (acc_rdata[7] == $past(busy)));  // R2

   AST_STATUS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_rs && acc_rw) |=> (acc_rdata[6:0] == $past(ac_q)));  // R2

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(busy) && $past(acc_valid) && !(!$past(acc_rs) && $past(acc_rw))));  // R13

   AST_DROP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && acc_valid && !(!acc_rs && acc_rw)) |=> ($stable(ac_q) && $stable(mode_bits)));  // R13

   AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !busy && !acc_rs && !acc_rw && acc_wdata == 8'h01) |=> (ac_q == 7'h00 && mode_bits[1]));  // R5

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(acc_valid) && !(!$past(acc_rs) && $past(acc_rw))));  // R12

endmodule

bind chardisp_ctrl chardisp_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_rs    (acc_rs),
   .acc_rw    (acc_rw),
   .acc_wdata (acc_wdata),
   .acc_rdata (acc_rdata),
   .busy      (busy),
   .err_pulse (err_pulse),
   .mode_bits (mode_bits),
   .ac_q      (ac_q)
);

// File: tb/test_chardisp_ctrl.sv
module test_chardisp_ctrl;

   localparam int CLK_KHZ   = 1000;
   localparam int LONG_CYC  = CLK_KHZ * 1530 / 1000;
   localparam int DATA_CYC  = CLK_KHZ * 43 / 1000;
   localparam int SHORT_CYC = CLK_KHZ * 39 / 1000;
   localparam int WATCHDOG  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic       acc_rs = 1'b0;
   logic       acc_rw = 1'b0;
   logic [7:0] acc_wdata = 8'h00;
   logic [7:0] acc_rdata;
   logic       busy;
   logic       err_pulse;
   logic [7:0] mode_bits;

   chardisp_ctrl #(.CLK_KHZ(CLK_KHZ)) i_chardisp_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_rs    (acc_rs),
      .acc_rw    (acc_rw),
      .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata),
      .busy      (busy),
      .err_pulse (err_pulse),
      .mode_bits (mode_bits)
   );

   always #5 clk = ~clk;

   // ---------------- reference model ----------------
   int         m_ac;
   bit         m_cg;
   bit [7:0]   m_dd [80];
   bit [7:0]   m_cgr [64];
   bit [7:0]   m_mode;
   bit [7:0]   m_rd;
   bit         m_err;
   int         m_busy;

   int         vectors = 0;
   int         miscompares = 0;
   int         cycles = 0;
   bit         done = 1'b0;
   string      cur_req = "R1";

   task automatic m_reset();
      m_ac = 0; m_cg = 0; m_mode = 8'h02; m_rd = 8'h00; m_err = 0; m_busy = 0;
      for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
      for (int i = 0; i < 64; i++) m_cgr[i] = 8'h00;
   endtask

   function automatic int m_index(int a);
      if (m_mode[6]) begin
         if (a < 40) return a;
         if (a >= 64 && a < 104) return a - 24;
         return -1;
      end
      if (a < 80) return a;
      return -1;
   endfunction

   function automatic int m_next(int a, bit up);
      if (m_cg) return up ? (a + 1) % 64 : (a + 63) % 64;
      if (m_mode[6]) begin
         if (up) return (a == 39) ? 64 : (a == 103) ? 0 : (a + 1) % 128;
         return (a == 64) ? 39 : (a == 0) ? 103 : (a + 127) % 128;
      end
      if (up) return (a == 79) ? 0 : (a + 1) % 128;
      return (a == 0) ? 79 : (a + 127) % 128;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reset();
      end else begin
         bit busy_now;
         int load;
         int w;
         int idx;
         busy_now = (m_busy > 0);
         load = 0;
         m_err = 0;
         w = int'(acc_wdata);
         if (acc_valid) begin
            if (!acc_rs && acc_rw) begin
               m_rd = {busy_now, 7'(m_ac)};
            end else if (busy_now) begin
               m_err = 1;
            end else if (acc_rs) begin
               load = DATA_CYC;
               idx = m_index(m_ac);
               if (!acc_rw) begin
                  if (m_cg) m_cgr[m_ac] = acc_wdata;
                  else if (idx >= 0) m_dd[idx] = acc_wdata;
               end else begin
                  if (m_cg) m_rd = m_cgr[m_ac];
                  else m_rd = (idx >= 0) ? m_dd[idx] : 8'h00;
               end
               m_ac = m_next(m_ac, m_mode[1]);
            end else begin
               load = SHORT_CYC;
               if (w >= 128) begin
                  m_ac = w - 128; m_cg = 0;
               end else if (w >= 64) begin
                  m_ac = w - 64; m_cg = 1;
               end else if (w >= 32) begin
                  m_mode[7] = acc_wdata[4]; m_mode[6] = acc_wdata[3]; m_mode[5] = acc_wdata[2];
               end else if (w >= 16) begin
                  if (!acc_wdata[3]) m_ac = m_next(m_ac, acc_wdata[2]);
               end else if (w >= 8) begin
                  m_mode[4] = acc_wdata[2]; m_mode[3] = acc_wdata[1]; m_mode[2] = acc_wdata[0];
               end else if (w >= 4) begin
                  m_mode[1] = acc_wdata[1]; m_mode[0] = acc_wdata[0];
               end else if (w >= 2) begin
                  load = LONG_CYC; m_ac = 0; m_cg = 0;
               end else if (w == 1) begin
                  load = LONG_CYC; m_ac = 0; m_cg = 0; m_mode[1] = 1;
                  for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
               end
            end
         end
         if (load > 0) m_busy = load;
         else if (m_busy > 0) m_busy = m_busy - 1;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         if (busy !== (m_busy > 0)) begin
            miscompares++;
            $display("FAIL R12 busy: actual %b expected %b (phase %s)", busy, (m_busy > 0), cur_req);
         end
         if (err_pulse !== m_err) begin
            miscompares++;
            $display("FAIL R13 err_pulse: actual %b expected %b (phase %s)", err_pulse, m_err, cur_req);
         end
         if (mode_bits !== m_mode) begin
            miscompares++;
            $display("FAIL R4 mode_bits: actual %h expected %h (phase %s)", mode_bits, m_mode, cur_req);
         end
         if (acc_rdata !== m_rd) begin
            miscompares++;
            $display("FAIL %s acc_rdata: actual %h expected %h", cur_req, acc_rdata, m_rd);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles >= WATCHDOG && !done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic access(bit rs, bit rw, bit [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_rs = rs; acc_rw = rw; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_wdata = 8'h00;
   endtask

   task automatic wait_idle();
      while (m_busy > 0) @(negedge clk);
   endtask

   task automatic instr(bit [7:0] d); access(0, 0, d); wait_idle(); endtask
   task automatic wr(bit [7:0] d);    access(1, 0, d); wait_idle(); endtask
   task automatic rd();               access(1, 1, 8'h00); wait_idle(); endtask
   task automatic status();           access(0, 1, 8'h00); endtask

   initial begin
      m_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      status();
      rd();
      rd();

      cur_req = "R4";
      instr(8'h38); status();
      instr(8'h0F); instr(8'h0C); instr(8'h05); instr(8'h06);
      instr(8'h00); status();

      cur_req = "R5";
      instr(8'h01); status();

      cur_req = "R3";
      wr(8'h41); wr(8'h42); wr(8'h43);
      instr(8'h80); rd(); rd(); rd(); status();
      instr(8'h04); instr(8'h85); wr(8'h5A); status(); instr(8'h85); rd(); status();
      instr(8'h06);

      cur_req = "R2";
      access(1, 0, 8'h77); status(); status(); wait_idle(); status();
      access(0, 0, 8'h01); status(); wait_idle();

      cur_req = "R13";
      instr(8'h90);
      access(1, 0, 8'h11); access(1, 0, 8'h99); access(1, 1, 8'h00); access(0, 0, 8'h02);
      status(); wait_idle(); status();
      instr(8'h90); rd(); rd();

      cur_req = "R8";
      instr(8'hA6); wr(8'hC1); wr(8'hC2); wr(8'hC3); status();
      instr(8'hE6); wr(8'hD1); wr(8'hD2); status();
      instr(8'hA6); rd(); rd(); rd(); instr(8'hE6); rd(); rd();
      instr(8'h04); instr(8'hC0); wr(8'hE1); status(); instr(8'h80); wr(8'hE2); status();
      instr(8'hC0); rd(); status(); rd(); status();
      instr(8'h06);

      cur_req = "R10";
      instr(8'hB0); wr(8'h55); status(); instr(8'hB0); rd(); status();
      instr(8'hFF); rd(); status();

      cur_req = "R11";
      instr(8'hA7); instr(8'h14); status(); instr(8'h14); status();
      instr(8'h10); status(); instr(8'h18); status(); instr(8'h1C); status();
      instr(8'h80); instr(8'h10); status();

      cur_req = "R9";
      instr(8'h30); status();
      instr(8'hCF); wr(8'hF1); status(); instr(8'hCF); rd(); status();
      instr(8'h04); instr(8'h80); rd(); status();
      instr(8'h06);
      instr(8'h80);
      for (int i = 0; i < 80; i++) wr(8'((i * 3 + 1) % 256));
      status();
      for (int i = 0; i < 80; i++) rd();
      instr(8'h38); instr(8'hC0); rd(); rd(); instr(8'hA7); rd(); rd(); status();
      instr(8'h30); instr(8'hD0); wr(8'h33); instr(8'h50 | 8'h80); rd(); status();

      cur_req = "R7";
      instr(8'h7F); wr(8'hA5); status(); wr(8'h5A); status();
      instr(8'h7F); rd(); rd(); status();
      instr(8'h04); instr(8'h40); rd(); status(); instr(8'h10); status();
      instr(8'h06);
      instr(8'h80); rd();
      instr(8'h14); status();

      cur_req = "R6";
      instr(8'h85); wr(8'h6B); instr(8'h03); status(); instr(8'h85); rd();
      instr(8'h45); instr(8'h02); status(); rd();

      cur_req = "R5";
      instr(8'h04); instr(8'h7A); instr(8'h01); status();
      rd(); rd(); instr(8'hC7); rd(); instr(8'hCF); rd(); status();
      instr(8'h40); rd();

      cur_req = "R12";
      instr(8'h02); instr(8'h08); wr(8'h01); rd();

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule